// File: doc/BRIEF.md
# SDRAM Early-Ending Read Sequencer

This block takes one read request at a time from a simple request port and turns it into SDRAM commands. The request names an open bank, a column, a wanted word count, and whether auto precharge is set. The block puts a READ on the command bus. It then stops the burst after the wanted number of words by issuing a burst-stop or a bank precharge command. That command goes out on the cycle that matches the selected CAS latency. The block samples the returned data and marks each wanted word as valid.

The CAS latency can be 2 or 3. The burst mode is either full page or a fixed length set by a parameter. The choice between the burst-stop command and precharge is made at the configuration inputs. All of these inputs are latched when a request is accepted, so they may change during a burst.

The command is placed so that it leads the last wanted word by one cycle less than the latency. Because of this, the command always falls exactly `L` cycles after the READ, where `L` is the effective word count, whatever the latency is. A fixed-length burst with auto precharge cannot be cut short, and neither can a request for at least the fixed burst length. In both cases the whole fixed burst is returned and no stop command is sent.

Top module: `sdram_rd_trunc`

## Requirements
- R1: A request is accepted at a clock edge where `req_valid` is high and `busy` is low. In the next cycle `sd_cmd` carries READ (3'b101), `sd_ba` carries the bank, `sd_addr` carries the column on its low bits with bit `AP_BIT` equal to `req_auto_pre` and all other bits zero, and `busy` is high.
- R2: With latency CL (`cfg_cl3`=0 gives 2, 1 gives 3), word k of the burst is on `sd_dq_in` in the cycle that is CL+k cycles after the READ cycle. It shows on `rd_data` with `rd_valid` high one cycle later.
- R3: When truncation applies, exactly one stop command is issued, L cycles after the READ. That is CL−1 cycles before the cycle that holds the last wanted word, for both latencies.
- R4: In full-page mode (`cfg_full_page`=1), L equals `req_len` and the burst is always truncated.
- R5: In fixed mode without auto precharge and with `req_len` < `FIXED_BL`, L equals `req_len` and the burst is truncated. The stop command is burst-stop (3'b110) when `cfg_trunc_pre`=0 and precharge (3'b010) when it is 1.
- R6: In fixed mode with auto precharge, the truncation request is refused. L equals `FIXED_BL` and no stop command is issued.
- R7: In fixed mode with `req_len` ≥ `FIXED_BL`, L equals `FIXED_BL` and no stop command is issued.
- R8: A precharge used as the stop command carries the request's bank on `sd_ba` and an all-zero `sd_addr`, so bit `AP_BIT` is low and only one bank is closed.
- R9: `rd_valid` is high for exactly L consecutive cycles per request, and `rd_last` is high on the final one only. No word after the last wanted one is captured.
- R10: In every cycle that carries neither the READ nor the stop command, `sd_cmd` is NOP (3'b111) with `sd_ba` and `sd_addr` zero. This includes idle cycles and the cycles after reset.
- R11: `sd_dqm` is all zeros while `busy` is high and all ones otherwise.
- R12: `busy` stays high until both the stop command has been issued and the last word has been captured. It falls in the cycle where `rd_last` is high, which is CL+L cycles after the READ. Requests seen while `busy` is high are ignored.
- R13: With L = 1 and latency 2, the stop command follows the READ in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request strobe |
| req_bank | input | BA_W | Bank of the open row |
| req_col | input | COL_W | Start column |
| req_len | input | LEN_W | Wanted word count, at least 1 |
| req_auto_pre | input | 1 | Auto precharge flag for this READ |
| cfg_cl3 | input | 1 | 0: latency 2, 1: latency 3 |
| cfg_full_page | input | 1 | 1: full-page bursts, 0: fixed length FIXED_BL |
| cfg_trunc_pre | input | 1 | 1: cut bursts with precharge instead of burst-stop |
| busy | output | 1 | Request in progress |
| sd_cmd | output | 3 | {RAS#, CAS#, WE#} command code |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| sd_dqm | output | DQ_W/8 | Byte masks |
| sd_dq_in | input | DQ_W | Read data from the SDRAM |
| rd_data | output | DQ_W | Captured word |
| rd_valid | output | 1 | `rd_data` holds a wanted word |
| rd_last | output | 1 | Final wanted word of the request |

## Verification
The checks assume that `req_len` is never zero when `req_valid` is high. They also assume that the command bus belongs to this block alone, so a precharge can always be placed in the cycle it needs. The stimulus only uses lengths from 1 to 63 and issues each request while `busy` is low, apart from one deliberate request made during a busy burst. A behavioural memory model drives the data bus only for the words that a correctly placed stop command allows, and drives a recognisable junk pattern in every other cycle. A stop command sent in the wrong cycle therefore shows up as wrong or missing data.

// File: rtl/sdram_rd_trunc_pkg.sv
package sdram_rd_trunc_pkg;
   // {RAS#, CAS#, WE#}
   typedef enum logic [2:0] {
      SDC_PRE  = 3'b010,
      SDC_READ = 3'b101,
      SDC_BST  = 3'b110,
      SDC_NOP  = 3'b111
   } sdc_e;
endpackage

// File: rtl/sdram_rd_trunc_plan.sv
module sdram_rd_trunc_plan
   import sdram_rd_trunc_pkg::*;
#(
   parameter int LEN_W    = 6,
   parameter int FIXED_BL = 8
) (
   input  logic [LEN_W-1:0] req_len,
   input  logic             req_auto_pre,
   input  logic             cfg_full_page,
   input  logic             cfg_trunc_pre,
   output logic [LEN_W-1:0] eff_len,
   output logic             need_stop,
   output sdc_e             stop_cmd
);
   localparam logic [LEN_W-1:0] BL_L = LEN_W'(FIXED_BL);

   always_comb begin
      if (cfg_full_page) begin
         eff_len   = req_len;
         need_stop = 1'b1;
      end else if (req_auto_pre || (req_len >= BL_L)) begin
         eff_len   = BL_L;
         need_stop = 1'b0;
      end else begin
         eff_len   = req_len;
         need_stop = 1'b1;
      end
      stop_cmd = cfg_trunc_pre ? SDC_PRE : SDC_BST;
   end
endmodule

// File: rtl/sdram_rd_trunc_timer.sv
module sdram_rd_trunc_timer
   import sdram_rd_trunc_pkg::*;
#(
   parameter int LEN_W  = 6,
   parameter int BA_W   = 2,
   parameter int COL_W  = 9,
   parameter int ADDR_W = 12,
   parameter int AP_BIT = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [BA_W-1:0]   req_bank,
   input  logic [COL_W-1:0]  req_col,
   input  logic              req_auto_pre,
   input  logic              cfg_cl3,
   input  logic [LEN_W-1:0]  eff_len,
   input  logic              need_stop,
   input  sdc_e              stop_cmd,
   output logic              busy,
   output sdc_e              cmd,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              cap_en,
   output logic              cap_last
);
   localparam int CNT_W = LEN_W + 2;

   logic              active;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  lat_q;
   logic [CNT_W-1:0]  len_q;
   logic              stop_q;
   sdc_e              stop_cmd_q;
   logic [BA_W-1:0]   bank_q;
   logic              accept;
   logic              stop_now;
   logic [CNT_W-1:0]  win_end;
   logic [ADDR_W-1:0] rd_addr;

   assign accept   = req_valid && !active;
   assign win_end  = lat_q + len_q;
   assign cap_en   = active && (cnt >= lat_q) && (cnt < win_end);
   assign cap_last = active && (cnt == win_end - CNT_W'(1));
   assign stop_now = active && stop_q && ((cnt + CNT_W'(1)) == len_q);
   assign busy     = active;

   always_comb begin
      rd_addr                = '0;
      rd_addr[COL_W-1:0]     = req_col;
      rd_addr[AP_BIT]        = req_auto_pre;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active     <= 1'b0;
         cnt        <= '0;
         lat_q      <= '0;
         len_q      <= '0;
         stop_q     <= 1'b0;
         stop_cmd_q <= SDC_BST;
         bank_q     <= '0;
         cmd        <= SDC_NOP;
         ba         <= '0;
         addr       <= '0;
      end else begin
         cmd  <= SDC_NOP;
         ba   <= '0;
         addr <= '0;
         if (accept) begin
            active     <= 1'b1;
            cnt        <= '0;
            lat_q      <= cfg_cl3 ? CNT_W'(3) : CNT_W'(2);
            len_q      <= CNT_W'(eff_len);
            stop_q     <= need_stop;
            stop_cmd_q <= stop_cmd;
            bank_q     <= req_bank;
            cmd        <= SDC_READ;
            ba         <= req_bank;
            addr       <= rd_addr;
         end else if (active) begin
            cnt <= cnt + CNT_W'(1);
            if (stop_now) begin
               cmd <= stop_cmd_q;
               if (stop_cmd_q == SDC_PRE) ba <= bank_q;
            end
            if (cap_last) active <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sdram_rd_trunc_capture.sv
module sdram_rd_trunc_capture #(
   parameter int DQ_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cap_en,
   input  logic            cap_last,
   input  logic [DQ_W-1:0] dq_in,
   output logic [DQ_W-1:0] rd_data,
   output logic            rd_valid,
   output logic            rd_last
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
         rd_last  <= 1'b0;
      end else begin
         rd_valid <= cap_en;
         rd_last  <= cap_en && cap_last;
         if (cap_en) rd_data <= dq_in;
      end
   end
endmodule

// File: rtl/sdram_rd_trunc.sv
module sdram_rd_trunc
   import sdram_rd_trunc_pkg::*;
#(
   parameter int BA_W     = 2,
   parameter int COL_W    = 9,
   parameter int ADDR_W   = 12,
   parameter int AP_BIT   = 10,
   parameter int DQ_W     = 16,
   parameter int LEN_W    = 6,
   parameter int FIXED_BL = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [BA_W-1:0]      req_bank,
   input  logic [COL_W-1:0]     req_col,
   input  logic [LEN_W-1:0]     req_len,
   input  logic                 req_auto_pre,
   input  logic                 cfg_cl3,
   input  logic                 cfg_full_page,
   input  logic                 cfg_trunc_pre,
   output logic                 busy,
   output logic [2:0]           sd_cmd,
   output logic [BA_W-1:0]      sd_ba,
   output logic [ADDR_W-1:0]    sd_addr,
   output logic [DQ_W/8-1:0]    sd_dqm,
   input  logic [DQ_W-1:0]      sd_dq_in,
   output logic [DQ_W-1:0]      rd_data,
   output logic                 rd_valid,
   output logic                 rd_last
);
   localparam int DQM_W = DQ_W / 8;

   if (AP_BIT < COL_W || AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("AP_BIT must sit above the column bits and inside the address bus");
   end
   if (FIXED_BL < 1 || FIXED_BL >= (1 << LEN_W)) begin : g_bad_bl
      $error("FIXED_BL must be at least 1 and fit in LEN_W bits");
   end
   if (DQ_W < 8 || (DQ_W % 8) != 0) begin : g_bad_dq
      $error("DQ_W must be a whole number of bytes");
   end

   logic [LEN_W-1:0] eff_len;
   logic             need_stop;
   sdc_e             stop_cmd;
   sdc_e             cmd;
   logic             cap_en;
   logic             cap_last;

   sdram_rd_trunc_plan #(.LEN_W(LEN_W), .FIXED_BL(FIXED_BL)) u_plan (
      .req_len       (req_len),
      .req_auto_pre  (req_auto_pre),
      .cfg_full_page (cfg_full_page),
      .cfg_trunc_pre (cfg_trunc_pre),
      .eff_len       (eff_len),
      .need_stop     (need_stop),
      .stop_cmd      (stop_cmd)
   );

   sdram_rd_trunc_timer #(
      .LEN_W(LEN_W), .BA_W(BA_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
   ) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_bank     (req_bank),
      .req_col      (req_col),
      .req_auto_pre (req_auto_pre),
      .cfg_cl3      (cfg_cl3),
      .eff_len      (eff_len),
      .need_stop    (need_stop),
      .stop_cmd     (stop_cmd),
      .busy         (busy),
      .cmd          (cmd),
      .ba           (sd_ba),
      .addr         (sd_addr),
      .cap_en       (cap_en),
      .cap_last     (cap_last)
   );

   sdram_rd_trunc_capture #(.DQ_W(DQ_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_last (cap_last),
      .dq_in    (sd_dq_in),
      .rd_data  (rd_data),
      .rd_valid (rd_valid),
      .rd_last  (rd_last)
   );

   assign sd_cmd = cmd;
   assign sd_dqm = busy ? {DQM_W{1'b0}} : {DQM_W{1'b1}};
endmodule

// File: rtl/sdram_rd_trunc_chk.sv
module sdram_rd_trunc_chk #(
   parameter int BA_W   = 2,
   parameter int ADDR_W = 12,
   parameter int AP_BIT = 10,
   parameter int DQ_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic [2:0]        sd_cmd,
   input logic [ADDR_W-1:0] sd_addr,
   input logic [DQ_W/8-1:0] sd_dqm,
   input logic              rd_valid,
   input logic              rd_last
);
   logic stop_seen;
   logic is_stop;

   assign is_stop = (sd_cmd == 3'b110) || (sd_cmd == 3'b010);

   always_ff @(posedge clk) begin
      if (!rst_n)                stop_seen <= 1'b0;
      else if (sd_cmd == 3'b101) stop_seen <= 1'b0;
      else if (is_stop)          stop_seen <= 1'b1;
   end

   AST_READ_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == 3'b101) |-> ($past(req_valid) && !$past(busy))); // R1
   AST_IDLE_BUS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sd_cmd == 3'b111)); // R10
   AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      is_stop |-> (busy && !stop_seen)); // R3
   AST_PRE_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == 3'b010) |-> !sd_addr[AP_BIT]); // R8
   AST_MASK_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (sd_dqm == '0)); // R11
   AST_MASK_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sd_dqm == '1)); // R11
   AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> rd_valid); // R9
   AST_VALID_FROM_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(busy)); // R2
   AST_BUSY_ENDS_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> rd_last); // R12
endmodule

bind sdram_rd_trunc sdram_rd_trunc_chk #(
   .BA_W(BA_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .DQ_W(DQ_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .sd_cmd    (sd_cmd),
   .sd_addr   (sd_addr),
   .sd_dqm    (sd_dqm),
   .rd_valid  (rd_valid),
   .rd_last   (rd_last)
);

// File: tb/sdram_rd_trunc_test.sv
`timescale 1ns/1ps
module sdram_rd_trunc_test;
   localparam int BA_W = 2, COL_W = 9, ADDR_W = 12, AP_BIT = 10;
   localparam int DQ_W = 16, LEN_W = 6, FIXED_BL = 8, DQM_W = DQ_W / 8;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, req_valid, req_auto_pre, cfg_cl3, cfg_full_page, cfg_trunc_pre;
   logic [BA_W-1:0] req_bank;
   logic [COL_W-1:0] req_col;
   logic [LEN_W-1:0] req_len;
   logic busy, rd_valid, rd_last;
   logic [2:0] sd_cmd;
   logic [BA_W-1:0] sd_ba;
   logic [ADDR_W-1:0] sd_addr;
   logic [DQM_W-1:0] sd_dqm;
   logic [DQ_W-1:0] sd_dq_in, rd_data;

   sdram_rd_trunc uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
      .req_col(req_col), .req_len(req_len), .req_auto_pre(req_auto_pre),
      .cfg_cl3(cfg_cl3), .cfg_full_page(cfg_full_page), .cfg_trunc_pre(cfg_trunc_pre),
      .busy(busy), .sd_cmd(sd_cmd), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
      .sd_dq_in(sd_dq_in), .rd_data(rd_data), .rd_valid(rd_valid), .rd_last(rd_last)
   );

   typedef struct { logic [DQ_W-1:0] d; bit last; } word_t;
   word_t exp_q[$];
   int n_chk = 0, n_bad = 0, cyc = 0;
   int cur_cl = 2;
   bit cur_full = 1'b0;
   logic [7:0] cur_tag = 8'h00, tag = 8'h00;
   bit m_on = 1'b0;
   int m_rd = 0, m_stop = 0, m_cl = 2;
   logic [7:0] m_tag = 8'h00;

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // Behavioural SDRAM read model
   always @(negedge clk) begin
      if (!rst_n) begin
         m_on = 1'b0;
         sd_dq_in = 16'hE000;
      end else begin
         if (sd_cmd == 3'b101) begin
            m_on = 1'b1; m_rd = cyc; m_cl = cur_cl; m_tag = cur_tag;
            m_stop = cur_full ? cyc + 100000 : cyc + m_cl + FIXED_BL;
         end else if (m_on && (sd_cmd == 3'b110 || sd_cmd == 3'b010)) begin
            if (cyc + m_cl < m_stop) m_stop = cyc + m_cl;
         end
         if (m_on && cyc >= m_rd + m_cl && cyc < m_stop)
            sd_dq_in = {m_tag, 8'(cyc - m_rd - m_cl)};
         else
            sd_dq_in = 16'hE000 ^ 16'(cyc & 255);
      end
   end

   // Monitor: pops expected words as the design delivers them
   always @(negedge clk) begin : mon
      word_t e;
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) chk(1'b0, "R9", "word beyond request", rd_data, 0);
         else begin
            e = exp_q.pop_front();
            chk(rd_data == e.d, "R2", "captured word", rd_data, e.d);
            chk(rd_last == e.last, "R9", "last flag", rd_last, e.last);
         end
      end
   end

   task automatic do_req(input string rq, input int len, input bit ap, input bit full,
                         input bit pre, input bit cl3, input bit poke);
      int cl, L, t;
      bit stp;
      logic [2:0] sc, ec;
      logic [BA_W-1:0] bk, eb;
      logic [COL_W-1:0] col;
      logic [ADDR_W-1:0] ea;
      cl = cl3 ? 3 : 2;
      if (full) begin L = len; stp = 1'b1; end
      else if (ap || len >= FIXED_BL) begin L = FIXED_BL; stp = 1'b0; end
      else begin L = len; stp = 1'b1; end
      sc = pre ? 3'b010 : 3'b110;
      tag = tag + 8'd1;
      bk = tag[BA_W-1:0];
      col = COL_W'(int'(tag) * 37);
      for (int k = 0; k < L; k++) exp_q.push_back('{d: {tag, 8'(k)}, last: (k == L - 1)});
      cur_cl = cl; cur_full = full; cur_tag = tag;
      req_valid = 1'b1; req_bank = bk; req_col = col; req_len = LEN_W'(len);
      req_auto_pre = ap; cfg_cl3 = cl3; cfg_full_page = full; cfg_trunc_pre = pre;
      @(negedge clk);
      req_valid = 1'b0; cfg_cl3 = ~cl3; cfg_full_page = ~full; cfg_trunc_pre = ~pre;
      req_auto_pre = ~ap; req_len = LEN_W'(1);
      ea = '0; ea[COL_W-1:0] = col; ea[AP_BIT] = ap;
      chk(sd_cmd == 3'b101, "R1", "READ command", sd_cmd, 3'b101);
      chk(sd_ba == bk && sd_addr == ea, "R1", "READ bank/address", {sd_ba, sd_addr}, {bk, ea});
      chk(busy == 1'b1, "R1", "busy at READ", busy, 1);
      t = 0;
      while (t < cl + L) begin
         @(negedge clk);
         t++;
         if (poke && t == 2) begin req_valid = 1'b1; req_len = LEN_W'(3); end
         if (poke && t == 3) req_valid = 1'b0;
         ec = (stp && t == L) ? sc : 3'b111;
         eb = (stp && t == L && pre) ? bk : '0;
         chk(sd_cmd == ec, rq, "command slot", sd_cmd, ec);
         chk(sd_ba == eb && sd_addr == '0, "R8", "bank/address on non-READ", {sd_ba, sd_addr}, {eb, 12'h0});
         chk(busy == (t < cl + L), "R12", "busy", busy, t < cl + L);
         chk(rd_valid == (t >= cl + 1), "R9", "valid window", rd_valid, t >= cl + 1);
         chk(sd_dqm == (busy ? {DQM_W{1'b0}} : {DQM_W{1'b1}}), "R11", "mask", sd_dqm, busy ? 0 : 3);
      end
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_bank = '0; req_col = '0; req_len = '0;
      req_auto_pre = 1'b0; cfg_cl3 = 1'b0; cfg_full_page = 1'b0; cfg_trunc_pre = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R12", "reset busy", busy, 0);
      chk(sd_cmd == 3'b111, "R10", "reset command", sd_cmd, 3'b111);
      chk(sd_dqm == {DQM_W{1'b1}}, "R11", "reset mask", sd_dqm, 3);
      chk(rd_valid == 1'b0, "R9", "reset valid", rd_valid, 0);
      do_req("R3", 4, 0, 1, 0, 0, 0);   // full page, latency 2, stop after 4
      do_req("R3", 4, 0, 1, 0, 1, 0);   // full page, latency 3
      do_req("R13", 1, 0, 1, 0, 0, 0);  // one word, latency 2
      do_req("R5", 1, 0, 0, 0, 1, 0);   // fixed, one word, latency 3
      do_req("R5", 5, 0, 0, 1, 0, 0);   // fixed, precharge stop
      do_req("R4", 20, 0, 1, 1, 1, 0);  // full page, precharge stop
      do_req("R6", 3, 1, 0, 0, 0, 0);   // auto precharge refuses truncation
      do_req("R7", 12, 0, 0, 0, 1, 0);  // longer than fixed burst
      do_req("R12", 7, 0, 0, 0, 1, 1);  // request during busy is ignored
      do_req("R4", 9, 1, 1, 0, 0, 0);   // full page with auto precharge still cut
      repeat (4) begin
         @(negedge clk);
         chk(sd_cmd == 3'b111 && busy == 1'b0, "R10", "idle bus", {busy, sd_cmd}, 3'b111);
      end
      chk(exp_q.size() == 0, "R9", "words still owed", exp_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule